// File: doc/BRIEF.md
# Shared-Generator Multi-Channel PWM

The block drives 33 output pins from a pool of 8 waveform generators. Pins 0 to 15 are direct outputs. Pins 16 to 32 feed a serial expander. A pin owns no counter. It selects one generator through a 4-bit map entry, and any number of pins may share one generator. Each generator holds an 8-bit period in time-base ticks and an 8-bit high count on a 255-step scale. Normal polarity applies, so every period starts with the high phase.

The time base arrives as a one-cycle strobe, `step_en`, that marks one sub-step. A generator with period P spends P sub-steps on each of its 255 duty steps. One full period is therefore 255·P strobes, and the high phase is H·P strobes. Software writes the configuration through a word-addressed register port that reads back what was written. A written period, high count or map entry goes into a shadow copy at once. The running generator and the pin adopt it only at a period boundary, so the waveform in progress is never cut short.

Top module: `pwm_pool`

## Requirements
- R1: After reset every pin is low and every register reads 0.
- R2: Register layout, one 32-bit word per address. Address 0 holds the periods of generators 0–3 and address 1 those of 4–7, one byte each, with the lowest generator in bits 7:0. Addresses 2–5 hold duty pairs for two generators each: the even generator in bits 15:0 and the odd one in bits 31:16. Each 16-bit half has the high count in its low byte and the low count in its high byte. Addresses 6–10 hold map entries for channels 8·(a−6) to 8·(a−6)+7, one nibble each, with the lowest channel in bits 3:0. In each nibble, bit 3 enables the channel and bits 2:0 give the generator number. Nibbles for channels above 32 read 0, and any other address reads 0 and ignores writes.
- R3: With active period P > 0 and high count H, a generator is high for the first H·P strobes of each 255·P-strobe period and low for the rest.
- R4: A high count of 0 gives a constant low output, and 255 gives a constant high output.
- R5: A new period or high count written while a generator runs takes effect only after its current period completes.
- R6: A generator whose active period is 0 is idle and drives low. It adopts its shadow settings on the next strobe, and that strobe starts its first period.
- R7: A written map entry takes effect when the generator it names next begins a period, or on the next strobe if that generator is idle.
- R8: A channel whose active map entry is disabled drives low.
- R9: Channels that select the same generator drive identical waveforms, whether they are direct or serial channels.
- R10: Pins change only in the cycle after a `step_en` strobe. Register writes alone never move a pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Time-base sub-step strobe |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| pin_out | output | 33 | Channel outputs: 0–15 direct, 16–32 serial |

## Verification
The bench rewrites a generator halfway through its period. A design that applied the new setting at once would cut the old waveform short, and the scoreboard would show a pin disagreeing on the very next strobe. It also checks the two duty extremes, 0 and 255. An off-by-one in the high-phase compare would let a 255 generator drop low for one duty step each period, or let a 0 generator flash high. It remaps and disables channels, and it brings an idle generator up from nothing. A design that updated the pin selection at write time, or at the old generator's boundary instead of the new one's, would move pins in cycles with no strobe or at the wrong step. It also reads back every packed register field, including the channel nibbles that do not exist. A shifted lane would show up as a wrong byte in the readback.

// File: rtl/pwm_pool_pkg.sv
package pwm_pool_pkg;

    localparam int NUM_GEN      = 8;
    localparam int GEN_W        = $clog2(NUM_GEN);
    localparam int NUM_DIRECT   = 16;
    localparam int NUM_SERIAL   = 17;
    localparam int NUM_CH       = NUM_DIRECT + NUM_SERIAL;
    localparam int CNT_W        = 8;
    localparam int DATA_W       = 32;
    localparam int ADDR_W       = 4;
    localparam int MAP_W        = GEN_W + 1;
    localparam int PER_PER_REG  = DATA_W / CNT_W;
    localparam int DUTY_PER_REG = DATA_W / (2 * CNT_W);
    localparam int MAP_PER_REG  = DATA_W / MAP_W;
    localparam int PER_BASE     = 0;
    localparam int DUTY_BASE    = PER_BASE + NUM_GEN / PER_PER_REG;
    localparam int MAP_BASE     = DUTY_BASE + NUM_GEN / DUTY_PER_REG;
    localparam logic [CNT_W-1:0] STEP_LAST = CNT_W'(254);

    typedef struct packed {
        logic             en;
        logic [GEN_W-1:0] id;
    } map_t;

    typedef struct packed {
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] high;
        logic [CNT_W-1:0] low;
    } gen_cfg_t;

    function automatic logic [ADDR_W-1:0] per_addr(int g);
        return ADDR_W'(PER_BASE + g / PER_PER_REG);
    endfunction

    function automatic logic [ADDR_W-1:0] duty_addr(int g);
        return ADDR_W'(DUTY_BASE + g / DUTY_PER_REG);
    endfunction

    function automatic logic [ADDR_W-1:0] map_addr(int c);
        return ADDR_W'(MAP_BASE + c / MAP_PER_REG);
    endfunction

endpackage

// File: rtl/pwm_pool_regs.sv
module pwm_pool_regs
    import pwm_pool_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           we,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [DATA_W-1:0]              wdata,
    output logic [DATA_W-1:0]              rdata,
    output gen_cfg_t [NUM_GEN-1:0]         cfg,
    output map_t     [NUM_CH-1:0]          chmap
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= '0;
            chmap <= '0;
        end else if (we) begin
            for (int g = 0; g < NUM_GEN; g++) begin
                if (addr == per_addr(g))
                    cfg[g].per <= wdata[(g % PER_PER_REG) * CNT_W +: CNT_W];
                if (addr == duty_addr(g)) begin
                    cfg[g].high <= wdata[(g % DUTY_PER_REG) * 2 * CNT_W +: CNT_W];
                    cfg[g].low  <= wdata[(g % DUTY_PER_REG) * 2 * CNT_W + CNT_W +: CNT_W];
                end
            end
            for (int c = 0; c < NUM_CH; c++) begin
                if (addr == map_addr(c))
                    chmap[c] <= wdata[(c % MAP_PER_REG) * MAP_W +: MAP_W];
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int g = 0; g < NUM_GEN; g++) begin
            if (addr == per_addr(g))
                rdata[(g % PER_PER_REG) * CNT_W +: CNT_W] = cfg[g].per;
            if (addr == duty_addr(g)) begin
                rdata[(g % DUTY_PER_REG) * 2 * CNT_W +: CNT_W]         = cfg[g].high;
                rdata[(g % DUTY_PER_REG) * 2 * CNT_W + CNT_W +: CNT_W] = cfg[g].low;
            end
        end
        for (int c = 0; c < NUM_CH; c++) begin
            if (addr == map_addr(c))
                rdata[(c % MAP_PER_REG) * MAP_W +: MAP_W] = chmap[c];
        end
    end

endmodule

// File: rtl/pwm_pool_gen.sv
module pwm_pool_gen
    import pwm_pool_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step_en,
    input  logic [CNT_W-1:0] shd_per,
    input  logic [CNT_W-1:0] shd_high,
    output logic             wave,
    output logic             load,
    output logic             idle
);

    logic [CNT_W-1:0] act_per, act_high, div_cnt, step_cnt;
    logic             div_last, period_end;

    assign idle       = (act_per == '0);
    assign div_last   = (div_cnt == act_per - CNT_W'(1));
    assign period_end = div_last && (step_cnt == STEP_LAST);
    assign load       = step_en && (idle || period_end);
    assign wave       = !idle && (step_cnt < act_high);

    always_ff @(posedge clk) begin
        if (rst) begin
            act_per  <= '0;
            act_high <= '0;
            div_cnt  <= '0;
            step_cnt <= '0;
        end else if (load) begin
            act_per  <= shd_per;
            act_high <= shd_high;
            div_cnt  <= '0;
            step_cnt <= '0;
        end else if (step_en) begin
            if (div_last) begin
                div_cnt  <= '0;
                step_cnt <= step_cnt + CNT_W'(1);
            end else begin
                div_cnt  <= div_cnt + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/pwm_pool_chan.sv
module pwm_pool_chan
    import pwm_pool_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  map_t               shd_map,
    input  logic [NUM_GEN-1:0] gen_load,
    input  logic [NUM_GEN-1:0] gen_wave,
    output logic               pin
);

    map_t act_map;

    always_ff @(posedge clk) begin
        if (rst)
            act_map <= '0;
        else if (gen_load[shd_map.id])
            act_map <= shd_map;
    end

    assign pin = act_map.en && gen_wave[act_map.id];

endmodule

// File: rtl/pwm_pool.sv
module pwm_pool
    import pwm_pool_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step_en,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NUM_CH-1:0] pin_out
);

    gen_cfg_t [NUM_GEN-1:0] cfg;
    map_t     [NUM_CH-1:0]  chmap;
    logic     [NUM_GEN-1:0] gen_load, gen_wave, gen_idle;

    pwm_pool_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cfg   (cfg),
        .chmap (chmap)
    );

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
        pwm_pool_gen u_gen (
            .clk      (clk),
            .rst      (rst),
            .step_en  (step_en),
            .shd_per  (cfg[g].per),
            .shd_high (cfg[g].high),
            .wave     (gen_wave[g]),
            .load     (gen_load[g]),
            .idle     (gen_idle[g])
        );
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        pwm_pool_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .shd_map  (chmap[c]),
            .gen_load (gen_load),
            .gen_wave (gen_wave),
            .pin      (pin_out[c])
        );
    end

endmodule

// File: rtl/pwm_pool_chk.sv
module pwm_pool_chk
    import pwm_pool_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               step_en,
    input logic [NUM_CH-1:0]  pin_out,
    input logic [NUM_GEN-1:0] gen_load,
    input logic [NUM_GEN-1:0] gen_wave
);

    // R1
    reset_low_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pin_out == '0));

    // R10
    pin_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(pin_out));

    // R5
    wave_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(gen_wave));

    // R7
    load_needs_step_chk: assert property (@(posedge clk) disable iff (rst)
        (gen_load != '0) |-> step_en);

endmodule

bind pwm_pool pwm_pool_chk u_chk (.*);

// File: tb/pwm_pool_bench.sv
module pwm_pool_bench;
    import pwm_pool_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              step_en = 1'b0;
    logic              reg_we = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic [NUM_CH-1:0] pin_out;

    always #4 clk = ~clk;

    pwm_pool u_pwm_pool (
        .clk       (clk),
        .rst       (rst),
        .step_en   (step_en),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pin_out   (pin_out)
    );

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic [NUM_CH-1:0] exp;
        string             req;
    } item_t;
    item_t sb_q[$];

    // Spec-level model of the requirements
    int         m_per_s[NUM_GEN]  = '{default: 0};
    int         m_high_s[NUM_GEN] = '{default: 0};
    int         m_per_a[NUM_GEN]  = '{default: 0};
    int         m_high_a[NUM_GEN] = '{default: 0};
    int         m_k[NUM_GEN]      = '{default: 0};
    logic [3:0] m_map_s[NUM_CH]   = '{default: 4'h0};
    logic [3:0] m_map_a[NUM_CH]   = '{default: 4'h0};

    task automatic check(string req, logic [NUM_CH-1:0] act, logic [NUM_CH-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [NUM_CH-1:0] model_out();
        logic [NUM_CH-1:0] v;
        for (int c = 0; c < NUM_CH; c++) begin
            int id = int'(m_map_a[c][2:0]);
            v[c] = m_map_a[c][3] && (m_per_a[id] != 0) &&
                   (m_k[id] < m_high_a[id] * m_per_a[id]);
        end
        return v;
    endfunction

    task automatic model_step();
        bit ld[NUM_GEN];
        for (int g = 0; g < NUM_GEN; g++)
            ld[g] = (m_per_a[g] == 0) || (m_k[g] == 255 * m_per_a[g] - 1);
        for (int c = 0; c < NUM_CH; c++)
            if (ld[int'(m_map_s[c][2:0])]) m_map_a[c] = m_map_s[c];
        for (int g = 0; g < NUM_GEN; g++) begin
            if (ld[g]) begin
                m_per_a[g]  = m_per_s[g];
                m_high_a[g] = m_high_s[g];
                m_k[g]      = 0;
            end else begin
                m_k[g]++;
            end
        end
    endtask

    task automatic model_write(int a, logic [31:0] d);
        if (a < 2)
            for (int n = 0; n < 4; n++) m_per_s[a * 4 + n] = int'(d[n * 8 +: 8]);
        else if (a < 6) begin
            m_high_s[(a - 2) * 2]     = int'(d[7:0]);
            m_high_s[(a - 2) * 2 + 1] = int'(d[23:16]);
        end else if (a <= 10)
            for (int n = 0; n < 8; n++)
                if ((a - 6) * 8 + n < NUM_CH) m_map_s[(a - 6) * 8 + n] = d[n * 4 +: 4];
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = ADDR_W'(a);
        reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd_check(int a, logic [31:0] exp, string req);
        @(negedge clk);
        reg_addr = ADDR_W'(a);
        #1;
        check(req, {1'b0, reg_rdata}, {1'b0, exp});
    endtask

    task automatic do_step(string req);
        item_t it;
        @(negedge clk);
        step_en = 1'b1;
        @(negedge clk);
        step_en = 1'b0;
        model_step();
        it.exp = model_out();
        it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic hold_check(string req);
        item_t it;
        @(negedge clk);
        it.exp = model_out();
        it.req = req;
        sb_q.push_back(it);
    endtask

    // Monitor: compares queued expectations with the pins
    always @(negedge clk) begin
        item_t it;
        #1;
        while (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            check(it.req, pin_out, it.exp);
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog R3: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        hold_check("R1");
        rd_check(0, 32'h0, "R1");
        rd_check(2, 32'h0, "R1");
        rd_check(6, 32'h0, "R1");
        rd_check(10, 32'h0, "R1");

        // R2: program and read back packed fields
        wr(0, 32'h04030201);
        wr(2, 32'h00FF7F80);
        wr(3, 32'hFC03FF00);
        wr(6, 32'h0008BA98);
        wr(10, 32'hFFFFFFF8);
        wr(12, 32'hFFFFFFFF);
        rd_check(0, 32'h04030201, "R2");
        rd_check(1, 32'h00000000, "R2");
        rd_check(2, 32'h00FF7F80, "R2");
        rd_check(3, 32'hFC03FF00, "R2");
        rd_check(6, 32'h0008BA98, "R2");
        rd_check(10, 32'h00000008, "R2");
        rd_check(12, 32'h00000000, "R2");
        // R10: writes alone move no pin
        hold_check("R10");

        // R6: idle generators start on the first strobe
        do_step("R6");
        repeat (300) do_step("R3");
        @(negedge clk);
        // R4: ch1 on full duty, ch2 on zero duty
        check("R4", {31'b0, pin_out[2:1]}, {31'b0, 2'b01});
        // R9: ch0, ch4 and serial ch32 share generator 0
        check("R9", {30'b0, pin_out[32], pin_out[4], pin_out[0]},
              {30'b0, {3{pin_out[0]}}});

        // R5 R7 R8: mid-period rewrites, remap, disable, new generator
        wr(0, 32'h04030202);
        wr(2, 32'h00FFF50A);
        wr(6, 32'h0000BAB8);
        wr(1, 32'h00000001);
        wr(4, 32'h0000FE01);
        wr(8, 32'h0000000C);
        hold_check("R10");
        do_step("R6");
        @(negedge clk);
        check("R6", {32'b0, pin_out[16]}, {32'b0, 1'b1});
        do_step("R6");
        repeat (1200) do_step("R5 R7 R8");
        @(negedge clk);
        check("R8", {32'b0, pin_out[4]}, 33'h0);
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule